// File: doc/BRIEF.md
# Four-Channel DMA Engine with Bus Handover

This block moves words between memory and I/O ports on behalf of a processor. Four independent channels each hold a source address, a destination address, a word count and a control byte, all loaded through a small write-only configuration port. Each channel also has a request line from its device. A request is caught in a pending latch, so a short request is not lost. A per-channel mask can hold a pending request back without dropping it. When several unmasked channels are pending, the lowest channel number is served first.

To move a word, the engine raises a bus request to the processor and waits for the grant. With the bus granted, it issues one read cycle at the source address and then one write cycle at the destination address. It then drops the request and waits for the grant to fall before it arbitrates again. Because each grant covers one word only, the processor and the other channels get turns between words.

Each address steps by one after every word, unless the channel marks that side as a fixed I/O port. When a channel's count runs out, its done flag sets. The interrupt line is the OR of the done flags whose interrupt mask is clear.

Top module: `dma_mover`

## Requirements
- R1: The engine drives a read or write strobe only while bus grant is high, and it raises bus request, then waits for grant, before any such cycle.
- R2: Each grant moves exactly one word: a read strobe at the source address, a write strobe two cycles later at the destination address with the word read, and then bus request goes low.
- R3: Among channels that are pending and not masked, the lowest channel number is chosen. The choice is made only while bus request is low.
- R4: A request input sampled high at a clock edge, while that channel's count is nonzero, sets the channel's pending latch. The latch stays set after the request falls, until one word is served. It also clears when the count reaches zero.
- R5: Control bit 0 set (request mask) stops a pending channel from being served, and the pending state is kept. Clearing the bit lets the remembered request be served.
- R6: After each word, the source and destination addresses each increase by one. Control bit 1 set keeps the source address fixed, and control bit 2 set keeps the destination address fixed.
- R7: The count drops by one per word. The channel's done flag (bit n of `done_o` for channel n) sets when a word is moved with a count of one.
- R8: `irq_o` is the OR of the done flags whose control bit 3 (interrupt mask) is clear. Writing register 4 with bit 0 set clears that channel's done flag, and writing it with bit 0 clear has no effect.
- R9: A request that arrives while the channel's count is zero is ignored. Loading a count later does not start a transfer.
- R10: The configuration address is {channel[1:0], reg[2:0]}: reg 0 is source, 1 is destination, 2 is count, 3 is control, 4 is done-clear. After reset, all registers and flags are zero and bus request and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration address {channel, register} |
| cfg_wdata_i | input | 8 | Configuration write data |
| dev_req_i | input | 4 | Per-channel device request |
| bus_req_o | output | 1 | Bus request to the processor |
| bus_gnt_i | input | 1 | Bus grant from the processor |
| bus_addr_o | output | 8 | Bus address (zero when not driving) |
| bus_rd_o | output | 1 | Read strobe; data returns the next cycle |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Completion interrupt |
| done_o | output | 4 | Per-channel done flags |

## Verification
On every cycle, the assertions check that bus strobes appear only under grant and that a read is followed two cycles later by a write and then a released request. They also check that the channel choice stays fixed while the bus is held and that a pending channel 0 wins every arbitration. Further assertions check that a zero count never leaves a channel pending, that the last word sets the done flag, and that the interrupt never rises without a done flag. Only the bench scenarios can show the data actually moved and the order of words under contention. They also show that a masked request is remembered and later served exactly once, that fixed-address modes repeat the right addresses, and that a request at zero count stays lost after a count is loaded.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_RD    = 3'd2,
    ST_RWAIT = 3'd3,
    ST_WR    = 3'd4,
    ST_REL   = 3'd5
  } xfer_state_t;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_CTL  = 3'd3;
  localparam logic [2:0] REG_DCLR = 3'd4;

  localparam int CTL_W        = 4;
  localparam int CTL_REQ_MASK = 0;
  localparam int CTL_SRC_FIX  = 1;
  localparam int CTL_DST_FIX  = 2;
  localparam int CTL_IRQ_MASK = 3;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hit_i,
  input  logic [2:0]        cfg_reg_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              dev_req_i,
  input  logic              served_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              pend_o,
  output logic              req_mask_o,
  output logic              irq_mask_o,
  output logic              done_o
);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a,
                                                   input logic fixed);
    return fixed ? a : a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CTL_W-1:0]  ctl_q;
  logic              pend_q, pend_d;
  logic              done_q;

  logic wr_src, wr_dst, wr_cnt, wr_ctl, wr_dclr;
  logic word_moved, last_word;

  assign wr_src  = cfg_hit_i && (cfg_reg_i == REG_SRC);
  assign wr_dst  = cfg_hit_i && (cfg_reg_i == REG_DST);
  assign wr_cnt  = cfg_hit_i && (cfg_reg_i == REG_CNT);
  assign wr_ctl  = cfg_hit_i && (cfg_reg_i == REG_CTL);
  assign wr_dclr = cfg_hit_i && (cfg_reg_i == REG_DCLR) && cfg_wdata_i[0];

  assign word_moved = served_i && (cnt_q != '0);
  assign last_word  = word_moved && (cnt_q == CNT_W'(1));

  always_comb begin
    if (wr_cnt)          cnt_d = cfg_wdata_i[CNT_W-1:0];
    else if (word_moved) cnt_d = cnt_step(cnt_q);
    else                 cnt_d = cnt_q;
    pend_d = ((pend_q && !word_moved) || dev_req_i) && (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      if (wr_src)          src_q <= cfg_wdata_i[ADDR_W-1:0];
      else if (word_moved) src_q <= addr_step(src_q, ctl_q[CTL_SRC_FIX]);
      if (wr_dst)          dst_q <= cfg_wdata_i[ADDR_W-1:0];
      else if (word_moved) dst_q <= addr_step(dst_q, ctl_q[CTL_DST_FIX]);
      if (wr_ctl)          ctl_q <= cfg_wdata_i[CTL_W-1:0];
      if (last_word)       done_q <= 1'b1;
      else if (wr_dclr)    done_q <= 1'b0;
    end
  end

  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign pend_o     = pend_q;
  assign req_mask_o = ctl_q[CTL_REQ_MASK];
  assign irq_mask_o = ctl_q[CTL_IRQ_MASK];
  assign done_o     = done_q;

  AST_ZERO_COUNT_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !wr_cnt) |=> !pend_q); // R9
  AST_LAST_WORD_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> done_q); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dclr && !last_word) |=> !done_q); // R8

endmodule

// File: rtl/dma_prio.sv
module dma_prio #(
  parameter int NCH  = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  elig_i,
  output logic            win_valid_o,
  output logic [CH_W-1:0] win_idx_o,
  output logic [NCH-1:0]  win_onehot_o
);

  always_comb begin
    win_idx_o    = '0;
    win_onehot_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        win_idx_o    = CH_W'(i);
        win_onehot_o = NCH'(1) << i;
      end
    end
    win_valid_o = |elig_i;
  end

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid_i,
  input  logic [CH_W-1:0]   win_idx_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_req_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [CH_W-1:0]   sel_o,
  output logic              start_o,
  output logic              served_o
);

  xfer_state_t       state_q;
  logic [CH_W-1:0]   sel_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (win_valid_i) begin
          sel_q   <= win_idx_i;
          state_q <= ST_REQ;
        end
        ST_REQ:   if (bus_gnt_i) state_q <= ST_RD;
        ST_RD:    state_q <= ST_RWAIT;
        ST_RWAIT: begin
          data_q  <= bus_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR:    state_q <= ST_REL;
        ST_REL:   if (!bus_gnt_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o   = (state_q == ST_REQ) || (state_q == ST_RD) ||
                  (state_q == ST_RWAIT) || (state_q == ST_WR);
    bus_rd_o    = (state_q == ST_RD);
    bus_wr_o    = (state_q == ST_WR);
    bus_addr_o  = bus_rd_o ? src_addr_i : (bus_wr_o ? dst_addr_i : '0);
    bus_wdata_o = bus_wr_o ? data_q : '0;
    start_o     = (state_q == ST_IDLE) && win_valid_i;
    served_o    = bus_wr_o;
  end

  assign sel_o = sel_q;

  AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_o || bus_wr_o) |-> (bus_gnt_i && bus_req_o)); // R1
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |=> ##1 bus_wr_o); // R2
  AST_RELEASE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |=> !bus_req_o); // R2

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CFG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W,
  localparam int CA_W  = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [CA_W-1:0]   cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [NCH-1:0]    dev_req_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              irq_o,
  output logic [NCH-1:0]    done_o
);

  logic [ADDR_W-1:0] src_a [NCH];
  logic [ADDR_W-1:0] dst_a [NCH];
  logic [NCH-1:0]    pend_w, req_mask_w, irq_mask_w, done_w, elig_w, win_onehot_w;
  logic              win_valid_w, start_w, served_w;
  logic [CH_W-1:0]   win_idx_w, sel_w;
  logic [CH_W-1:0]   cfg_ch_w;
  logic [2:0]        cfg_reg_w;

  assign cfg_ch_w  = cfg_addr_i[CA_W-1:3];
  assign cfg_reg_w = cfg_addr_i[2:0];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_hit_i   (cfg_we_i && (cfg_ch_w == CH_W'(g))),
      .cfg_reg_i   (cfg_reg_w),
      .cfg_wdata_i (cfg_wdata_i),
      .dev_req_i   (dev_req_i[g]),
      .served_i    (served_w && (sel_w == CH_W'(g))),
      .src_o       (src_a[g]),
      .dst_o       (dst_a[g]),
      .pend_o      (pend_w[g]),
      .req_mask_o  (req_mask_w[g]),
      .irq_mask_o  (irq_mask_w[g]),
      .done_o      (done_w[g])
    );
  end

  assign elig_w = pend_w & ~req_mask_w;

  dma_prio #(.NCH(NCH)) u_prio (
    .elig_i       (elig_w),
    .win_valid_o  (win_valid_w),
    .win_idx_o    (win_idx_w),
    .win_onehot_o (win_onehot_w)
  );

  dma_xfer #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_valid_i (win_valid_w),
    .win_idx_i   (win_idx_w),
    .src_addr_i  (src_a[sel_w]),
    .dst_addr_i  (dst_a[sel_w]),
    .bus_gnt_i   (bus_gnt_i),
    .bus_rdata_i (bus_rdata_i),
    .bus_req_o   (bus_req_o),
    .bus_rd_o    (bus_rd_o),
    .bus_wr_o    (bus_wr_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .sel_o       (sel_w),
    .start_o     (start_w),
    .served_o    (served_w)
  );

  assign done_o = done_w;
  assign irq_o  = |(done_w & ~irq_mask_w);

  AST_WINNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot_w) && ((win_onehot_w & ~elig_w) == '0)); // R3
  AST_CH0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && elig_w[0]) |=> (sel_w == '0)); // R3
  AST_NO_REARB_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |=> $stable(sel_w)); // R3
  AST_MASKED_NOT_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |-> !req_mask_w[win_idx_w]); // R5
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (done_o != '0)); // R8

endmodule

// File: tb/dma_mover_tb.sv
module dma_mover_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  dev_req = '0;
  logic        bus_req, bus_gnt = 1'b0, bus_rd, bus_wr, irq;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata = '0;
  logic [3:0]  done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_mover u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .dev_req_i(dev_req), .bus_req_o(bus_req),
    .bus_gnt_i(bus_gnt), .bus_addr_o(bus_addr), .bus_rd_o(bus_rd),
    .bus_wr_o(bus_wr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .irq_o(irq), .done_o(done)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 37) ^ 16'hA5C3);
  endfunction

  logic [15:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = pat(i);

  always @(posedge clk) begin
    bus_gnt <= rst_n && bus_req;
    if (bus_rd) bus_rdata <= mem[bus_addr];
    if (bus_wr) mem[bus_addr] <= bus_wdata;
  end

  typedef struct { logic [7:0] a; logic [15:0] d; string tag; } exp_t;
  exp_t exp_q[$];
  int   n_checks = 0, n_fail = 0, req_rises = 0;
  logic prev_req = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(bit ok, string r, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, expv);
    end
  endtask

  task automatic push_word(int a, int d, string tag);
    exp_t e;
    e.a = 8'(a); e.d = 16'(d); e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops the scoreboard on each write cycle
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n) begin
      if (bus_req && !prev_req) req_rises++;
      prev_req = bus_req;
      if (bus_wr) begin
        if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected write addr", bus_addr, 0);
        else begin
          e = exp_q.pop_front();
          chk(bus_addr == e.a, e.tag, "write address", bus_addr, e.a);
          chk(bus_wdata == e.d, e.tag, "write data", bus_wdata, e.d);
        end
      end
    end
  end

  task automatic cfg_write(int ch, int rg, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'((ch << 3) | rg); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(int ch, int src, int dst, int cnt, int ctl);
    cfg_write(ch, 0, src);
    cfg_write(ch, 1, dst);
    cfg_write(ch, 3, ctl);
    cfg_write(ch, 2, cnt);
  endtask

  task automatic drain(string r);
    int n = 0;
    repeat (3) @(negedge clk);
    while ((exp_q.size() != 0 || bus_req) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 2000, r, "transfers drained (pending words)", exp_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, "R10", "bus_req in reset", bus_req, 0);
    chk(irq == 1'b0, "R10", "irq in reset", irq, 0);
    chk(done == 4'b0, "R10", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 R7: channel 2 incrementing both sides, three words, one tenure each (R2)
    setup(2, 8'h10, 8'h80, 3, 0);
    for (int i = 0; i < 3; i++) push_word(8'h80 + i, pat(8'h10 + i), "R6");
    r0 = req_rises;
    dev_req[2] = 1'b1;
    drain("R6");
    dev_req[2] = 1'b0;
    chk(req_rises - r0 == 3, "R2", "bus tenures for 3 words", req_rises - r0, 3);
    chk(done == 4'b0100, "R7", "done after count hits zero", done, 4'b0100);
    chk(irq == 1'b1, "R8", "irq with unmasked done", irq, 1);
    cfg_write(2, 4, 0);
    chk(done == 4'b0100, "R8", "clear write with bit0=0 ignored", done, 4'b0100);
    cfg_write(2, 4, 1);
    chk(done == 4'b0000, "R8", "done cleared", done, 0);
    chk(irq == 1'b0, "R8", "irq after clear", irq, 0);

    // R3: channels 0 and 3 requested together, channel 0 first
    setup(0, 8'h30, 8'hB0, 2, 0);
    setup(3, 8'h50, 8'hC0, 2, 0);
    push_word(8'hB0, pat(8'h30), "R3");
    push_word(8'hB1, pat(8'h31), "R3");
    push_word(8'hC0, pat(8'h50), "R3");
    push_word(8'hC1, pat(8'h51), "R3");
    r0 = req_rises;
    @(negedge clk);
    dev_req = 4'b1001;
    drain("R3");
    dev_req = 4'b0000;
    chk(req_rises - r0 == 4, "R2", "one tenure per word under contention", req_rises - r0, 4);
    chk(done == 4'b1001, "R7", "done for channels 0 and 3", done, 4'b1001);
    cfg_write(0, 4, 1);
    cfg_write(3, 4, 1);

    // R5 R4: masked channel 1 keeps its pending request, served once on unmask
    setup(1, 8'h60, 8'hD0, 2, 1);
    r0 = req_rises;
    @(negedge clk);
    dev_req[1] = 1'b1;
    repeat (2) @(negedge clk);
    dev_req[1] = 1'b0;
    repeat (30) @(negedge clk);
    chk(req_rises == r0, "R5", "no bus request while masked", req_rises - r0, 0);
    push_word(8'hD0, pat(8'h60), "R4");
    cfg_write(1, 3, 0);
    drain("R4");
    repeat (20) @(negedge clk);
    chk(req_rises - r0 == 1, "R4", "remembered request served once", req_rises - r0, 1);
    chk(done[1] == 1'b0, "R7", "done stays low with count left", done[1], 0);

    // R6: fixed source on channel 3, fixed destination on channel 0
    setup(3, 8'h70, 8'hE0, 3, 2);
    for (int i = 0; i < 3; i++) push_word(8'hE0 + i, pat(8'h70), "R6");
    @(negedge clk);
    dev_req[3] = 1'b1;
    drain("R6");
    dev_req[3] = 1'b0;
    setup(0, 8'h20, 8'hF0, 2, 4);
    push_word(8'hF0, pat(8'h20), "R6");
    push_word(8'hF0, pat(8'h21), "R6");
    @(negedge clk);
    dev_req[0] = 1'b1;
    drain("R6");
    dev_req[0] = 1'b0;
    chk(done == 4'b1001, "R7", "done after fixed-address runs", done, 4'b1001);

    // R8: interrupt mask
    cfg_write(3, 3, 8);
    cfg_write(0, 4, 1);
    chk(done == 4'b1000, "R8", "masked done still visible", done, 4'b1000);
    chk(irq == 1'b0, "R8", "irq low with only masked done", irq, 0);
    cfg_write(3, 3, 0);
    chk(irq == 1'b1, "R8", "irq after unmask", irq, 1);
    cfg_write(3, 4, 1);
    chk(irq == 1'b0, "R8", "irq after final clear", irq, 0);

    // R9: request while count is zero is dropped
    r0 = req_rises;
    @(negedge clk);
    dev_req[2] = 1'b1;
    repeat (3) @(negedge clk);
    dev_req[2] = 1'b0;
    repeat (5) @(negedge clk);
    cfg_write(2, 2, 1);
    repeat (20) @(negedge clk);
    chk(req_rises == r0, "R9", "no transfer from zero-count request", req_rises - r0, 0);
    chk(done == 4'b0000, "R9", "done untouched", done, 0);

    chk(exp_q.size() == 0, "R6", "scoreboard empty at end", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule